// File: doc/BRIEF.md
# Line Overhead Alarm and Error Monitor

This block watches the line overhead of a SONET receiver one frame at a time. An upstream framer pulls the overhead bytes out of each frame and computes the local B2 parity. It then presents the values in one cycle with a frame strobe: the low three bits of the first K2 byte, the received B2 bytes, the locally computed B2 bytes, and the Z2 far-end error count. The block keeps two line alarms. One is line AIS, raised on the all-ones pattern. The other is line remote defect, raised on pattern 110. Each alarm passes through a persistence filter, so a single stray frame cannot change it.

Two saturating counters track errors. The first adds up the errored B2 bits. The second adds up the far-end block error values reported in Z2. A host reads either counter with a one-cycle request. The read returns the current count and clears the counter in the same cycle. A mode input selects STS-3c, which has three interleaved B2 bytes, or STS-1, which has one.

Top module: `line_oh_monitor`

## Requirements
- R1: The AIS alarm (`lineAis`) rises at the end of the fifth frame in a row whose K2 bits 6..8 (port `k2Low`, bit 8 = LSB) equal 3'b111.
- R2: Once `lineAis` is high, it falls at the end of the fifth frame in a row whose K2 bits are not 3'b111.
- R3: The remote defect alarm (`lineRdi`) follows the same five-frame rise and fall rule for the pattern 3'b110.
- R4: A cycle with `frameValid` low never moves an alarm, whatever the inputs carry.
- R5: A frame that breaks a run restarts that run. For example, four qualifying frames, one breaking frame and four more qualifying frames leave the alarm unchanged.
- R6: In STS-3c mode (`sts3cMode`=1), each frame adds the number of differing bits between `b2Rx[23:0]` and `b2Calc[23:0]` to the B2 counter. The counter is 20 bits wide.
- R7: In STS-1 mode, only bits [7:0] take part in the B2 comparison. Bits [23:8] are ignored.
- R8: Each frame adds `z2Febe`, read as an unsigned byte, to the 18-bit FEBE counter. The value is first clamped to 24 in STS-3c mode and to 8 in STS-1 mode.
- R9: Both counters saturate. The B2 counter stops at 1048575 and the FEBE counter stops at 262143.
- R10: A pulse on `rdReq` selects a counter with `rdSel` (0 = B2, 1 = FEBE). One cycle later, `rdValid` is high for one cycle and `rdData` holds the count as it stood before the request, zero-extended.
- R11: The read clears the selected counter. If a frame arrives in the same cycle, the counter restarts from that frame's increment alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sts3cMode | input | 1 | 1 = STS-3c (three B2 bytes), 0 = STS-1 |
| frameValid | input | 1 | One-cycle strobe per frame qualifying the overhead inputs |
| k2Low | input | 3 | Bits 6..8 of the first K2 byte |
| b2Rx | input | 24 | Received B2 bytes, channel 1 in [7:0] |
| b2Calc | input | 24 | Locally computed B2 parity, same layout |
| z2Febe | input | 8 | Far-end block error count from Z2 |
| rdReq | input | 1 | Host read-and-clear request |
| rdSel | input | 1 | Counter select: 0 = B2, 1 = FEBE |
| rdData | output | 20 | Snapshot of the selected counter |
| rdValid | output | 1 | Marks rdData valid |
| lineAis | output | 1 | Filtered line AIS alarm |
| lineRdi | output | 1 | Filtered line remote defect alarm |

## Verification
The alarm filters get several kinds of input. Clean runs of four and five frames separate the set threshold from one frame too early. A run broken in the middle shows that the count restarts instead of carrying over. Idle cycles with a matching pattern on the K2 input show that only strobed frames count, and the AIS pattern is driven while the remote defect alarm is observed, which shows the two patterns are told apart. On the counter side, single-bit and multi-byte parity differences are used, and the same differences are repeated in STS-1 mode to show the byte masking. Z2 values are chosen below, at and above each clamp limit. A long burst of fully errored frames drives both counters into saturation. A read issued in the same cycle as a frame shows that the snapshot and the restart stay separate.

// File: rtl/line_mon_pkg.sv
package line_mon_pkg;
  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic frameTick;
    logic rdStrobe;
    logic clrB2;
    logic clrFebe;
  } monStrobes_t;
endpackage

// File: rtl/persist_filter.sv
module persist_filter #(
  parameter int unsigned RUN_LEN = 5,
  parameter int unsigned FIELD_W = 3,
  parameter logic [FIELD_W-1:0] PATTERN = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frameTick,
  input  logic [FIELD_W-1:0] field,
  output logic               alarmOut
);
  localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);

  logic [CNT_W-1:0] runCnt;
  logic             alarmQ;
  logic             patMatch;

  assign patMatch = (field == PATTERN);
  assign alarmOut = alarmQ;

  // Count frames that disagree with the present alarm state; an agreeing
  // frame breaks the run and restarts it.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarmQ <= 1'b0;
      runCnt <= '0;
    end else if (frameTick) begin
      if (patMatch != alarmQ) begin
        if (runCnt == CNT_W'(RUN_LEN - 1)) begin
          alarmQ <= ~alarmQ;
          runCnt <= '0;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end else begin
        runCnt <= '0;
      end
    end
  end

  // R1/R3: a rise needs a strobed matching frame
  a_r1_rise_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarmQ) |-> $past(frameTick && patMatch));
  // R2: a fall needs a strobed non-matching frame
  a_r2_fall_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarmQ) |-> $past(frameTick && !patMatch));
  // R4: idle cycles hold the alarm
  a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !frameTick |=> $stable(alarmQ));
  // R5: a breaking frame empties the run
  a_r5_break_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (frameTick && (patMatch == alarmQ)) |=> (runCnt == '0));
endmodule

// File: rtl/line_mon_ctrl.sv
module line_mon_ctrl
  import line_mon_pkg::*;
#(
  parameter int unsigned RUN_LEN = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frameValid,
  input  logic [2:0]  k2Low,
  input  logic        rdReq,
  input  logic        rdSel,
  output monStrobes_t strb,
  output logic        lineAis,
  output logic        lineRdi
);
  localparam int unsigned NUM_ALARMS = 2;
  localparam logic [2:0] AIS_PAT = 3'b111;
  localparam logic [2:0] RDI_PAT = 3'b110;

  logic [NUM_ALARMS-1:0] alarmVec;

  for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_alarm
    localparam logic [2:0] PAT = (i == 0) ? AIS_PAT : RDI_PAT;
    persist_filter #(
      .RUN_LEN(RUN_LEN),
      .FIELD_W(3),
      .PATTERN(PAT)
    ) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .frameTick(frameValid),
      .field    (k2Low),
      .alarmOut (alarmVec[i])
    );
  end

  assign lineAis = alarmVec[0];
  assign lineRdi = alarmVec[1];

  always_comb begin
    strb.frameTick = frameValid;
    strb.rdStrobe  = rdReq;
    strb.clrB2     = rdReq && !rdSel;
    strb.clrFebe   = rdReq && rdSel;
  end

  // R3: the two patterns are exclusive, so both alarms cannot rise together
  a_r3_no_joint_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(lineAis) && $rose(lineRdi)));
endmodule

// File: rtl/line_mon_datapath.sv
module line_mon_datapath
  import line_mon_pkg::*;
#(
  parameter int unsigned B2_BYTES   = 3,
  parameter int unsigned B2_CNT_W   = 20,
  parameter int unsigned FEBE_CNT_W = 18,
  parameter int unsigned RD_W       = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  monStrobes_t           strb,
  input  logic                  sts3cMode,
  input  logic [B2_BYTES*8-1:0] b2Rx,
  input  logic [B2_BYTES*8-1:0] b2Calc,
  input  logic [7:0]            z2Febe,
  output logic [RD_W-1:0]       rdData,
  output logic                  rdValid
);
  localparam int unsigned MAX_ERR   = B2_BYTES * 8;
  localparam int unsigned INC_W     = $clog2(MAX_ERR + 1);
  localparam logic [B2_CNT_W-1:0]   B2_MAX   = '1;
  localparam logic [FEBE_CNT_W-1:0] FEBE_MAX = '1;
  localparam logic [7:0] LIM_FULL = 8'(MAX_ERR);
  localparam logic [7:0] LIM_ONE  = 8'd8;

  logic [B2_BYTES-1:0]   byteEn;
  logic [INC_W-1:0]      byteErr [B2_BYTES];
  logic [INC_W-1:0]      b2Inc;
  logic [7:0]            febeLim;
  logic [7:0]            febeInc;
  logic [B2_CNT_W-1:0]   b2Cnt, b2Base, b2Next;
  logic [FEBE_CNT_W-1:0] febeCnt, febeBase, febeNext;
  logic [B2_CNT_W:0]     b2Sum;
  logic [FEBE_CNT_W:0]   febeSum;

  // Channel 1 is always active; the others only in the wide mode
  for (genvar i = 0; i < B2_BYTES; i++) begin : g_chan
    if (i == 0) begin : g_first
      assign byteEn[i] = 1'b1;
    end else begin : g_rest
      assign byteEn[i] = sts3cMode;
    end
    assign byteErr[i] = byteEn[i]
      ? INC_W'($countones(b2Rx[i*8 +: 8] ^ b2Calc[i*8 +: 8])) : '0;
  end

  always_comb begin
    b2Inc = '0;
    for (int i = 0; i < B2_BYTES; i++) begin
      b2Inc = b2Inc + byteErr[i];
    end
  end

  assign febeLim = sts3cMode ? LIM_FULL : LIM_ONE;
  assign febeInc = (z2Febe > febeLim) ? febeLim : z2Febe;

  // Read-and-clear: the cleared base takes this cycle's increment
  assign b2Base   = strb.clrB2   ? '0 : b2Cnt;
  assign febeBase = strb.clrFebe ? '0 : febeCnt;
  assign b2Sum    = {1'b0, b2Base} +
                    (B2_CNT_W + 1)'(strb.frameTick ? b2Inc : '0);
  assign febeSum  = {1'b0, febeBase} +
                    (FEBE_CNT_W + 1)'(strb.frameTick ? febeInc : 8'd0);
  assign b2Next   = b2Sum[B2_CNT_W]     ? B2_MAX   : b2Sum[B2_CNT_W-1:0];
  assign febeNext = febeSum[FEBE_CNT_W] ? FEBE_MAX : febeSum[FEBE_CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b2Cnt   <= '0;
      febeCnt <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      b2Cnt   <= b2Next;
      febeCnt <= febeNext;
      rdValid <= strb.rdStrobe;
      if (strb.rdStrobe) begin
        rdData <= strb.clrB2 ? RD_W'(b2Cnt) : RD_W'(febeCnt);
      end
    end
  end

  // R6: without a clear the B2 count never drops
  a_r6_b2_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.clrB2 |=> (b2Cnt >= $past(b2Cnt)));
  // R8: one frame adds at most the full-mode limit to FEBE
  a_r8_febe_step: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.clrFebe |=> ((febeCnt - $past(febeCnt)) <= FEBE_CNT_W'(MAX_ERR)));
  // R9: a saturated counter stays saturated until read
  a_r9_b2_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (b2Cnt == B2_MAX && !strb.clrB2) |=> (b2Cnt == B2_MAX));
  a_r9_febe_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (febeCnt == FEBE_MAX && !strb.clrFebe) |=> (febeCnt == FEBE_MAX));
  // R10: a request yields exactly one valid cycle
  a_r10_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    strb.rdStrobe |=> rdValid);
  a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.rdStrobe |=> !rdValid);
  // R11: a cleared counter holds no more than one frame's worth
  a_r11_clear_b2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clrB2 |=> (b2Cnt <= B2_CNT_W'(MAX_ERR)));
endmodule

// File: rtl/line_oh_monitor.sv
module line_oh_monitor
  import line_mon_pkg::*;
#(
  parameter int unsigned RUN_LEN    = 5,
  parameter int unsigned B2_BYTES   = 3,
  parameter int unsigned B2_CNT_W   = 20,
  parameter int unsigned FEBE_CNT_W = 18,
  parameter int unsigned RD_W = (B2_CNT_W > FEBE_CNT_W) ? B2_CNT_W : FEBE_CNT_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sts3cMode,
  input  logic                  frameValid,
  input  logic [2:0]            k2Low,
  input  logic [B2_BYTES*8-1:0] b2Rx,
  input  logic [B2_BYTES*8-1:0] b2Calc,
  input  logic [7:0]            z2Febe,
  input  logic                  rdReq,
  input  logic                  rdSel,
  output logic [RD_W-1:0]       rdData,
  output logic                  rdValid,
  output logic                  lineAis,
  output logic                  lineRdi
);
  monStrobes_t strb;

  line_mon_ctrl #(.RUN_LEN(RUN_LEN)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .frameValid(frameValid),
    .k2Low     (k2Low),
    .rdReq     (rdReq),
    .rdSel     (rdSel),
    .strb      (strb),
    .lineAis   (lineAis),
    .lineRdi   (lineRdi)
  );

  line_mon_datapath #(
    .B2_BYTES  (B2_BYTES),
    .B2_CNT_W  (B2_CNT_W),
    .FEBE_CNT_W(FEBE_CNT_W),
    .RD_W      (RD_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .sts3cMode(sts3cMode),
    .b2Rx     (b2Rx),
    .b2Calc   (b2Calc),
    .z2Febe   (z2Febe),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );
endmodule

// File: tb/tb_line_oh_monitor.sv
`timescale 1ns/1ps
module tb_line_oh_monitor;
  localparam int unsigned B2_MAXV   = 1048575;
  localparam int unsigned FEBE_MAXV = 262143;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sts3cMode = 1'b1;
  logic        frameValid = 1'b0;
  logic [2:0]  k2Low = 3'b000;
  logic [23:0] b2Rx = '0;
  logic [23:0] b2Calc = '0;
  logic [7:0]  z2Febe = '0;
  logic        rdReq = 1'b0;
  logic        rdSel = 1'b0;
  logic [19:0] rdData;
  logic        rdValid;
  logic        lineAis, lineRdi;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int unsigned expB2 = 0;
  int unsigned expFebe = 0;
  int unsigned expQ[$];
  string tagQ[$];

  always #5 clk = ~clk;

  line_oh_monitor dut (
    .clk(clk), .rst_n(rst_n), .sts3cMode(sts3cMode), .frameValid(frameValid),
    .k2Low(k2Low), .b2Rx(b2Rx), .b2Calc(b2Calc), .z2Febe(z2Febe),
    .rdReq(rdReq), .rdSel(rdSel), .rdData(rdData), .rdValid(rdValid),
    .lineAis(lineAis), .lineRdi(lineRdi)
  );

  task automatic check(input bit ok, input string tag, input int unsigned act,
                       input int unsigned exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int unsigned b2Errs(input logic [23:0] rx, input logic [23:0] calc,
                                         input bit wide);
    logic [23:0] d = rx ^ calc;
    if (!wide) d[23:8] = '0;
    return $countones(d);
  endfunction

  function automatic int unsigned febeVal(input logic [7:0] z, input bit wide);
    int unsigned lim = wide ? 24 : 8;
    return (z > lim) ? lim : z;
  endfunction

  // Driver: one cycle, optional frame and optional read; called at a negedge
  task automatic step(input bit fv, input logic [2:0] k2, input logic [23:0] rx,
                      input logic [23:0] calc, input logic [7:0] z,
                      input bit rd, input bit sel, input string tag);
    int unsigned addB2, addFebe;
    addB2   = fv ? b2Errs(rx, calc, sts3cMode) : 0;
    addFebe = fv ? febeVal(z, sts3cMode) : 0;
    if (rd) begin
      expQ.push_back(sel ? expFebe : expB2);
      tagQ.push_back(tag);
      if (sel) expFebe = 0; else expB2 = 0;
    end
    expB2   = (expB2 + addB2 > B2_MAXV) ? B2_MAXV : expB2 + addB2;
    expFebe = (expFebe + addFebe > FEBE_MAXV) ? FEBE_MAXV : expFebe + addFebe;
    frameValid = fv; k2Low = k2; b2Rx = rx; b2Calc = calc; z2Febe = z;
    rdReq = rd; rdSel = sel;
    @(negedge clk);
    frameValid = 1'b0; rdReq = 1'b0;
  endtask

  task automatic k2Frames(input logic [2:0] k2, input int n);
    for (int i = 0; i < n; i++) step(1, k2, '0, '0, 8'd0, 0, 0, "");
  endtask

  task automatic readCnt(input bit sel, input string tag);
    step(0, 3'b000, '0, '0, 8'd0, 1, sel, tag);
  endtask

  // Monitor: pop and compare each read result
  always @(negedge clk) begin
    if (rst_n && rdValid) begin
      if (expQ.size() == 0) begin
        check(0, "R10 unexpected rdValid", 1, 0);
      end else begin
        automatic int unsigned e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(rdData == e, t, rdData, e);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(!lineAis, "R1 reset AIS", lineAis, 0);
    check(!lineRdi, "R3 reset RDI", lineRdi, 0);
    check(!rdValid, "R10 reset rdValid", rdValid, 0);
    readCnt(0, "R6 reset B2 count");

    // R1: four frames are not enough, the fifth sets AIS
    k2Frames(3'b111, 4);
    check(!lineAis, "R1 AIS after 4", lineAis, 0);
    // R4: idle cycles carrying the pattern do not count
    frameValid = 0; k2Low = 3'b111;
    repeat (3) @(negedge clk);
    check(!lineAis, "R4 idle does not set", lineAis, 0);
    k2Frames(3'b111, 1);
    check(lineAis, "R1 AIS after 5", lineAis, 1);
    check(!lineRdi, "R3 RDI ignores 111", lineRdi, 0);

    // R5/R2: broken clear run restarts
    k2Frames(3'b000, 3);
    k2Frames(3'b111, 1);
    k2Frames(3'b000, 4);
    check(lineAis, "R5 AIS held after broken clear", lineAis, 1);
    k2Frames(3'b010, 1);
    check(!lineAis, "R2 AIS cleared after 5", lineAis, 0);

    // R3: remote defect with broken set run
    k2Frames(3'b110, 4);
    k2Frames(3'b111, 1);
    k2Frames(3'b110, 4);
    check(!lineRdi, "R5 RDI not set after broken run", lineRdi, 0);
    k2Frames(3'b110, 1);
    check(lineRdi, "R3 RDI set after 5", lineRdi, 1);
    k2Frames(3'b111, 4);
    check(lineRdi, "R3 RDI held after 4 others", lineRdi, 1);
    k2Frames(3'b001, 1);
    check(!lineRdi, "R3 RDI cleared after 5", lineRdi, 0);

    // R6: STS-3c B2 errors across bytes
    readCnt(0, "R6 pre-clear B2");
    readCnt(1, "R8 pre-clear FEBE");
    sts3cMode = 1;
    step(1, 3'b000, 24'h000001, 24'h000000, 8'd3, 0, 0, "");
    step(1, 3'b000, 24'hFF0F01, 24'h00F000, 8'd24, 0, 0, "");
    step(1, 3'b000, 24'h800000, 24'h000080, 8'd200, 0, 0, "");
    readCnt(0, "R6 STS-3c B2 sum");
    readCnt(0, "R11 B2 cleared by read");
    readCnt(1, "R8 STS-3c FEBE sum with clamp 24");

    // R7: STS-1 masks upper bytes; R8 clamp 8
    sts3cMode = 0;
    step(1, 3'b000, 24'hFFFF03, 24'h000000, 8'd7, 0, 0, "");
    step(1, 3'b000, 24'hABCD00, 24'h000000, 8'd9, 0, 0, "");
    step(1, 3'b000, 24'h000000, 24'h0000F0, 8'd255, 0, 0, "");
    readCnt(0, "R7 STS-1 B2 masked");
    readCnt(1, "R8 STS-1 FEBE clamp 8");

    // R11: read in the same cycle as a frame
    sts3cMode = 1;
    step(1, 3'b000, 24'h00000F, 24'h0, 8'd5, 0, 0, "");
    step(1, 3'b000, 24'h000007, 24'h0, 8'd2, 1, 0, "R11 snapshot with concurrent frame");
    readCnt(0, "R11 restart holds concurrent increment");
    readCnt(1, "R8 FEBE total");

    // R9: saturation of both counters
    for (int i = 0; i < 44000; i++) step(1, 3'b000, 24'hFFFFFF, 24'h0, 8'd24, 0, 0, "");
    readCnt(0, "R9 B2 saturated");
    readCnt(1, "R9 FEBE saturated");
    readCnt(0, "R11 B2 zero after saturated read");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R10 all reads answered", expQ.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule